// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block sits between a flash array's read path and its data bus. It forms what a host sees on reads while an internal program or erase algorithm runs. The command decoder pulses a start signal on the rising edge of the last write of a sequence. It also supplies the operation kind and the top bit of the word being programmed. The algorithm engine pulses a done signal when it finishes.

While the operation is busy, each read returns a status word instead of array data. The top bit reports the complement of the programmed bit, or 0 during an erase. Bits 6 and 2 invert after every completed read access. All other bits read 0. An active-high ready output drops for the duration of the operation. Once the operation ends, reads pass array data through untouched.

A read access is open while both `oe_n` and `ce_n` are low. It completes on the first clock where either strobe is high again. All strobe and control inputs are sampled on `clk`. The read bus is a plain combinational output with no handshake and no back-pressure. A host polls by toggling the strobes, and the block never stalls a read.

Top module: `esr_status_reporter`

## Requirements
- R1: While `rst_n` is low, `ready` is 1 and `rd_data` equals `array_data`.
- R2: A cycle with `op_start` high and `hw_reset` low, while idle, makes `ready` 0 from the next cycle. `ready` stays 0 until the cycle after `op_done` is seen high.
- R3: While a program operation (`op_kind` = 2'b00) is busy, `rd_data[7]` equals the inverse of the `prog_msb` value captured with `op_start`.
- R4: While an erase operation (`op_kind` 2'b01 sector, 2'b10 whole array, 2'b11 treated as erase) is busy, `rd_data[7]` is 0.
- R5: While busy, `rd_data[6]` is 0 at the start of an operation. It inverts once per completed read access and holds its value between accesses.
- R6: While busy, `rd_data[2]` always equals `rd_data[6]`.
- R7: While busy, every bit of `rd_data` other than 7, 6 and 2 reads 0.
- R8: While idle, `rd_data` equals `array_data`, including during a read access. The toggle state is cleared, so the next operation again starts with bits 6 and 2 at 0.
- R9: `hw_reset` high ends a busy operation, so `ready` is 1 from the next cycle. While `hw_reset` is high, `op_start` is ignored.
- R10: An `op_start` arriving while already busy is ignored. The kind and the captured bit of the running operation are unchanged.
- R11: `prog_msb` and `op_kind` are captured only with an accepted `op_start`. Later changes on those inputs do not alter the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_reset | input | 1 | Synchronous abort of any running operation |
| op_start | input | 1 | Pulse at the last write of a program or erase sequence |
| op_kind | input | 2 | 00 program, 01 sector erase, 10 whole-array erase, 11 erase |
| prog_msb | input | 1 | Top bit of the word being programmed |
| op_done | input | 1 | Pulse from the algorithm engine on completion |
| oe_n | input | 1 | Active-low output-enable strobe |
| ce_n | input | 1 | Active-low chip-enable strobe |
| array_data | input | DW | Normal read data from the array |
| rd_data | output | DW | Data presented to the bus |
| ready | output | 1 | 1 when no operation is running |

## Verification
The hardest situations to reach are the overlapping ones. One is a second start pulse landing in the middle of an open read access. Another is an abort that coincides with a start request. Either can corrupt the captured operation or the toggle phase without changing the ready pin.

The bench sweeps every array pattern and every operation kind. In each case it raises a conflicting start during the second read of the operation. It alternates which strobe closes each access. It drives a new value on the programmed bit right after capture, then checks that the status word does not follow it. A separate pass holds the abort high together with a start for several cycles.

// File: rtl/esr_pkg.sv
package esr_pkg;
  typedef enum logic [1:0] {
    OP_PROG   = 2'b00,
    OP_SERASE = 2'b01,
    OP_CERASE = 2'b10,
    OP_RSVD   = 2'b11
  } op_kind_t;
endpackage

// File: rtl/esr_strobe_edge.sv
module esr_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n,
  input  logic ce_n,
  output logic access,
  output logic release_p
);
  logic access_q;

  assign access = ~oe_n & ~ce_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) access_q <= 1'b0;
    else        access_q <= access;
  end

  assign release_p = access_q & ~access;

  // R5
  release_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_p |-> $past(access));
endmodule

// File: rtl/esr_op_tracker.sv
module esr_op_tracker
  import esr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hw_reset,
  input  logic     op_start,
  input  logic     op_done,
  input  logic [1:0] op_kind,
  input  logic     prog_msb,
  output logic     busy,
  output op_kind_t kind_q,
  output logic     msb_q
);
  logic accept;

  assign accept = op_start & ~busy & ~hw_reset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      kind_q <= OP_PROG;
      msb_q  <= 1'b0;
    end else begin
      if (hw_reset)     busy <= 1'b0;
      else if (busy)    busy <= ~op_done;
      else if (op_start) busy <= 1'b1;
      if (accept) begin
        kind_q <= op_kind_t'(op_kind);
        msb_q  <= prog_msb;
      end
    end
  end

  // R2
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && op_start && !hw_reset) |=> busy);
  // R2
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_done) |=> !busy);
  // R9
  abort_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_reset |=> !busy);
  // R10
  capture_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(kind_q) && $stable(msb_q)));
endmodule

// File: rtl/esr_toggle.sv
module esr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic release_p,
  output logic tog
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tog <= 1'b0;
    else if (!busy) tog <= 1'b0;
    else            tog <= tog ^ release_p;
  end

  // R5
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && release_p) |=> (tog != $past(tog)));
  // R5
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !release_p) |=> $stable(tog));
  // R8
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !tog);
endmodule

// File: rtl/esr_status_fmt.sv
module esr_status_fmt
  import esr_pkg::*;
#(
  parameter int DW      = 8,
  parameter int POLL_B  = 7,
  parameter int TOG_HI  = 6,
  parameter int TOG_LO  = 2
) (
  input  logic          busy,
  input  op_kind_t      kind_q,
  input  logic          msb_q,
  input  logic          tog,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data
);
  logic poll_bit;

  assign poll_bit = (kind_q == OP_PROG) ? ~msb_q : 1'b0;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i == POLL_B) begin : g_poll
      assign rd_data[i] = busy ? poll_bit : array_data[i];
    end else if (i == TOG_HI || i == TOG_LO) begin : g_tog
      assign rd_data[i] = busy ? tog : array_data[i];
    end else begin : g_zero
      assign rd_data[i] = busy ? 1'b0 : array_data[i];
    end
  end
endmodule

// File: rtl/esr_status_reporter.sv
module esr_status_reporter
  import esr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_reset,
  input  logic          op_start,
  input  logic [1:0]    op_kind,
  input  logic          prog_msb,
  input  logic          op_done,
  input  logic          oe_n,
  input  logic          ce_n,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data,
  output logic          ready
);
  localparam int POLL_B = DW - 1;

  logic     busy;
  logic     access;
  logic     release_p;
  logic     tog;
  logic     msb_q;
  op_kind_t kind_q;

  esr_strobe_edge u_edge (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .ce_n(ce_n),
    .access(access), .release_p(release_p)
  );

  esr_op_tracker u_track (
    .clk(clk), .rst_n(rst_n), .hw_reset(hw_reset), .op_start(op_start),
    .op_done(op_done), .op_kind(op_kind), .prog_msb(prog_msb),
    .busy(busy), .kind_q(kind_q), .msb_q(msb_q)
  );

  esr_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .busy(busy), .release_p(release_p), .tog(tog)
  );

  esr_status_fmt #(.DW(DW), .POLL_B(POLL_B), .TOG_HI(6), .TOG_LO(2)) u_fmt (
    .busy(busy), .kind_q(kind_q), .msb_q(msb_q), .tog(tog),
    .array_data(array_data), .rd_data(rd_data)
  );

  assign ready = ~busy;

  // R8
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (rd_data == array_data));
  // R6
  toggle_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (rd_data[6] == rd_data[2]));
  // R4
  erase_poll_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && kind_q != OP_PROG) |-> !rd_data[POLL_B]);
  // R5
  open_read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access && $past(access) && !ready && $past(!ready)) |-> $stable(rd_data[6]));
endmodule

// File: tb/esr_status_reporter_bench.sv
module esr_status_reporter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_reset = 1'b0;
  logic       op_start = 1'b0;
  logic [1:0] op_kind = 2'b00;
  logic       prog_msb = 1'b0;
  logic       op_done = 1'b0;
  logic       oe_n = 1'b1;
  logic       ce_n = 1'b1;
  logic [7:0] array_data = 8'h00;
  logic [7:0] rd_data;
  logic       ready;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  esr_status_reporter #(.DW(8)) u_esr_status_reporter (
    .clk(clk), .rst_n(rst_n), .hw_reset(hw_reset), .op_start(op_start),
    .op_kind(op_kind), .prog_msb(prog_msb), .op_done(op_done),
    .oe_n(oe_n), .ce_n(ce_n), .array_data(array_data),
    .rd_data(rd_data), .ready(ready)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] status(input logic [1:0] k, input logic m, input logic t);
    logic [7:0] s;
    s = 8'h00;
    s[7] = (k == 2'b00) ? ~m : 1'b0;
    s[6] = t;
    s[2] = t;
    return s;
  endfunction

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    array_data = 8'h5A;
    tick();
    // R1 reset state
    chk("R1 ready", {7'd0, ready}, 8'd1);
    chk("R1 data", rd_data, 8'h5A);
    rst_n = 1'b1;
    tick();

    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < 256; p++) begin
        logic m;
        logic [7:0] exp;
        m = p[0] ^ p[7] ^ k[0];
        array_data = p[7:0];
        #1;
        chk("R8 idle pass", rd_data, p[7:0]);
        op_start = 1'b1; op_kind = k[1:0]; prog_msb = m;
        tick();
        op_start = 1'b0; prog_msb = ~m; op_kind = ~k[1:0];
        #1;
        chk("R2 busy", {7'd0, ready}, 8'd0);
        chk("R11 capture", rd_data, status(k[1:0], m, 1'b0));
        for (int r = 0; r < 3; r++) begin
          oe_n = 1'b0; ce_n = 1'b0;
          tick();
          exp = status(k[1:0], m, r[0]);
          chk("R3 R4 R5 R6 R7 read", rd_data, exp);
          if (r == 1) begin
            op_start = 1'b1; op_kind = (k == 0) ? 2'b01 : 2'b00; prog_msb = m;
            tick();
            op_start = 1'b0;
            chk("R10 restart ignored", rd_data, exp);
          end
          if (r[0]) ce_n = 1'b1; else oe_n = 1'b1;
          tick();
          oe_n = 1'b1; ce_n = 1'b1;
          tick();
          chk("R5 hold between", rd_data, status(k[1:0], m, ~r[0]));
        end
        op_done = 1'b1;
        tick();
        op_done = 1'b0;
        chk("R2 ready after done", {7'd0, ready}, 8'd1);
        oe_n = 1'b0;
        tick();
        chk("R8 read after done", rd_data, p[7:0]);
        oe_n = 1'b1;
        tick();
        chk("R8 stable after done", rd_data, p[7:0]);
      end
    end

    // R9 abort, start ignored while abort held
    array_data = 8'hC3;
    op_start = 1'b1; op_kind = 2'b00; prog_msb = 1'b0;
    tick();
    op_start = 1'b0;
    chk("R9 busy before abort", {7'd0, ready}, 8'd0);
    hw_reset = 1'b1; op_start = 1'b1;
    tick();
    chk("R9 abort ready", {7'd0, ready}, 8'd1);
    chk("R9 abort data", rd_data, 8'hC3);
    tick();
    chk("R9 start ignored in abort", {7'd0, ready}, 8'd1);
    hw_reset = 1'b0; op_start = 1'b0;
    tick();
    chk("R9 read mode", rd_data, 8'hC3);
    // R8 next operation begins with toggle at 0
    op_start = 1'b1; op_kind = 2'b01;
    tick();
    op_start = 1'b0;
    chk("R8 fresh toggle", rd_data, 8'h00);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule